// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive request lines and drives two request outputs toward a processor: a normal interrupt and a fast interrupt. Each output has its own enable mask over the same raw level vector. The output is high while any request is both asserted and enabled in that output's mask. Software changes a mask through separate set and clear word offsets, so it never has to read, modify and write the mask. It can read masked and raw status, and it can raise or lower request line 0 on its own as a soft interrupt.

The register port is a simple single-cycle access: an enable, a write flag, a 4-bit word offset and a data word. Read data is registered and appears in the cycle after the read access. Both interrupt outputs are registered, so they can be fed straight into an input line of another instance to build a cascade. An access to an offset that does not allow that direction produces a one-cycle error strobe and has no other effect.

Top module: `dualmask_intc`

## Requirements
- R1: After synchronous reset, both enable masks and the soft bit are zero, and `irq_out`, `fiq_out`, `err_pulse` and `rd_data` are all low.
- R2: A read of word 1 returns the raw level, word 0 returns raw level AND the normal mask, and word 2 returns the normal mask. `rd_data` shows the value in the cycle after the read access and holds it until the next read.
- R3: A write to word 2 ORs the data into the normal mask. A write to word 3 clears the mask bits that are 1 in the data. All other mask bits are kept.
- R4: A read of word 8 returns raw level AND the fast mask, word 9 returns the raw level, and word 10 returns the fast mask. A write to word 10 sets fast mask bits and a write to word 11 clears them.
- R5: A write to word 4 with data bit 0 = 1 sets the soft bit, and a write to word 5 with data bit 0 = 1 clears it. Data bit 0 = 0 and all other data bits have no effect. A read of word 4 returns raw level bit 0 in bit 0 and zero in bits 31..1.
- R6: Raw level bit 0 is the OR of input line 0 and the soft bit. Clearing the soft bit while input line 0 is high leaves line 0 asserted.
- R7: `irq_out` is high in the cycle after any bit of raw level AND normal mask is set, and `fiq_out` is high likewise for the fast mask. Inputs are not latched: an output falls one cycle after its request drops.
- R8: Reads of words 3, 5, 11, 6, 7 and 12 to 15 return zero. Writes to words 0, 1, 8, 9, 6, 7 and 12 to 15 change no state. `err_pulse` is high for exactly the cycle after such an access and low after a legal one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 32 | Level-sensitive request inputs |
| acc_en | input | 1 | Register access in this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_word | input | 4 | Word offset of the access |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_out | output | 1 | Normal interrupt request, registered |
| fiq_out | output | 1 | Fast interrupt request, registered |
| err_pulse | output | 1 | One-cycle strobe after an illegal access |

## Verification
The collision that matters is a soft-clear write to line 0 landing in the same cycle that hardware input 0 rises, with line 0 enabled for the normal output. The bench drives both edges together. It expects `irq_out` to stay high through the write and the following cycle, and expects a raw-status read and a word-4 read to show bit 0 still set. Only after the input drops does it expect the output to fall. Every expectation is queued with its target cycle and compared when that cycle arrives.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int WORD_W = 4;
  typedef logic [WORD_W-1:0] word_t;

  localparam word_t OFS_IRQ_MSTAT  = 4'd0;
  localparam word_t OFS_IRQ_RAW    = 4'd1;
  localparam word_t OFS_IRQ_EN     = 4'd2;
  localparam word_t OFS_IRQ_EN_CLR = 4'd3;
  localparam word_t OFS_SOFT       = 4'd4;
  localparam word_t OFS_SOFT_CLR   = 4'd5;
  localparam word_t OFS_FIQ_MSTAT  = 4'd8;
  localparam word_t OFS_FIQ_RAW    = 4'd9;
  localparam word_t OFS_FIQ_EN     = 4'd10;
  localparam word_t OFS_FIQ_EN_CLR = 4'd11;

  localparam int CH_IRQ = 0;
  localparam int CH_FIQ = 1;
  localparam int N_CH   = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IRQ_MSTAT,
    SEL_RAW,
    SEL_IRQ_EN,
    SEL_SOFT,
    SEL_FIQ_MSTAT,
    SEL_FIQ_EN
  } rd_sel_e;

  typedef struct packed {
    logic    irq_set;
    logic    irq_clr;
    logic    fiq_set;
    logic    fiq_clr;
    logic    soft_set;
    logic    soft_clr;
    logic    rd_en;
    rd_sel_e rd_sel;
    logic    bad;
  } dec_t;
endpackage

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
(
  input  logic  acc_en,
  input  logic  acc_wr,
  input  word_t acc_word,
  input  logic  wbit0,
  output dec_t  dec
);
  always_comb begin
    dec.irq_set  = 1'b0;
    dec.irq_clr  = 1'b0;
    dec.fiq_set  = 1'b0;
    dec.fiq_clr  = 1'b0;
    dec.soft_set = 1'b0;
    dec.soft_clr = 1'b0;
    dec.rd_en    = 1'b0;
    dec.rd_sel   = SEL_NONE;
    dec.bad      = 1'b0;
    if (acc_en) begin
      if (acc_wr) begin
        case (acc_word)
          OFS_IRQ_EN:     dec.irq_set  = 1'b1;
          OFS_IRQ_EN_CLR: dec.irq_clr  = 1'b1;
          OFS_FIQ_EN:     dec.fiq_set  = 1'b1;
          OFS_FIQ_EN_CLR: dec.fiq_clr  = 1'b1;
          OFS_SOFT:       dec.soft_set = wbit0;
          OFS_SOFT_CLR:   dec.soft_clr = wbit0;
          default:        dec.bad      = 1'b1;
        endcase
      end else begin
        dec.rd_en = 1'b1;
        case (acc_word)
          OFS_IRQ_MSTAT:            dec.rd_sel = SEL_IRQ_MSTAT;
          OFS_IRQ_RAW, OFS_FIQ_RAW: dec.rd_sel = SEL_RAW;
          OFS_IRQ_EN:               dec.rd_sel = SEL_IRQ_EN;
          OFS_SOFT:                 dec.rd_sel = SEL_SOFT;
          OFS_FIQ_MSTAT:            dec.rd_sel = SEL_FIQ_MSTAT;
          OFS_FIQ_EN:               dec.rd_sel = SEL_FIQ_EN;
          default:                  dec.bad    = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst)         mask_q <= '0;
    else if (set_en) mask_q <= mask_q | wdata;
    else if (clr_en) mask_q <= mask_q & ~wdata;
  end

  // R3 for the normal channel, R4 for the fast channel
  p_set_sticks_r3: assert property (@(posedge clk) disable iff (rst)
    set_en |=> ((mask_q & $past(wdata)) == $past(wdata)));
  p_clr_drops_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !set_en) |=> ((mask_q & $past(wdata)) == '0));
  p_set_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    set_en |=> ((mask_q & $past(mask_q)) == $past(mask_q)));
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!set_en && !clr_en) |=> $stable(mask_q));
endmodule

// File: rtl/intc_out_stage.sv
module intc_out_stage #(
  parameter int W    = 32,
  parameter int N_CH = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [W-1:0]            raw_lvl,
  input  logic [N_CH-1:0][W-1:0]  masks,
  output logic [N_CH-1:0]         out_q
);
  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) out_q[g] <= 1'b0;
      else     out_q[g] <= |(raw_lvl & masks[g]);
    end

    p_raise_r7: assert property (@(posedge clk) disable iff (rst)
      (|(raw_lvl & masks[g])) |=> out_q[g]);
    p_drop_r7: assert property (@(posedge clk) disable iff (rst)
      ((raw_lvl & masks[g]) == '0) |=> !out_q[g]);
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (out_q == '0));
endmodule

// File: rtl/dualmask_intc.sv
module dualmask_intc
  import intc_pkg::*;
#(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_lines,
  input  logic               acc_en,
  input  logic               acc_wr,
  input  logic [WORD_W-1:0]  acc_word,
  input  logic [N_LINES-1:0] acc_wdata,
  output logic [N_LINES-1:0] rd_data,
  output logic               irq_out,
  output logic               fiq_out,
  output logic               err_pulse
);
  localparam int HI_ZEROS = N_LINES - 1;

  dec_t                         dec;
  logic                         soft_q;
  logic [N_LINES-1:0]           raw_lvl;
  logic [N_CH-1:0]              set_v;
  logic [N_CH-1:0]              clr_v;
  logic [N_CH-1:0][N_LINES-1:0] mask_v;
  logic [N_CH-1:0]              out_v;
  logic [N_LINES-1:0]           rd_next;
  logic [N_LINES-1:0]           rd_q;
  logic                         err_q;

  intc_decode u_dec (
    .acc_en   (acc_en),
    .acc_wr   (acc_wr),
    .acc_word (acc_word),
    .wbit0    (acc_wdata[0]),
    .dec      (dec)
  );

  assign set_v[CH_IRQ] = dec.irq_set;
  assign clr_v[CH_IRQ] = dec.irq_clr;
  assign set_v[CH_FIQ] = dec.fiq_set;
  assign clr_v[CH_FIQ] = dec.fiq_clr;

  for (genvar g = 0; g < N_CH; g++) begin : g_mask
    intc_mask_reg #(.W(N_LINES)) u_mask (
      .clk    (clk),
      .rst    (rst),
      .set_en (set_v[g]),
      .clr_en (clr_v[g]),
      .wdata  (acc_wdata),
      .mask_q (mask_v[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)               soft_q <= 1'b0;
    else if (dec.soft_set) soft_q <= 1'b1;
    else if (dec.soft_clr) soft_q <= 1'b0;
  end

  assign raw_lvl = irq_lines | {{HI_ZEROS{1'b0}}, soft_q};

  intc_out_stage #(.W(N_LINES), .N_CH(N_CH)) u_out (
    .clk     (clk),
    .rst     (rst),
    .raw_lvl (raw_lvl),
    .masks   (mask_v),
    .out_q   (out_v)
  );

  always_comb begin
    case (dec.rd_sel)
      SEL_IRQ_MSTAT: rd_next = raw_lvl & mask_v[CH_IRQ];
      SEL_RAW:       rd_next = raw_lvl;
      SEL_IRQ_EN:    rd_next = mask_v[CH_IRQ];
      SEL_SOFT:      rd_next = {{HI_ZEROS{1'b0}}, raw_lvl[0]};
      SEL_FIQ_MSTAT: rd_next = raw_lvl & mask_v[CH_FIQ];
      SEL_FIQ_EN:    rd_next = mask_v[CH_FIQ];
      default:       rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (dec.rd_en) rd_q <= rd_next;
      err_q <= dec.bad;
    end
  end

  assign rd_data   = rd_q;
  assign irq_out   = out_v[CH_IRQ];
  assign fiq_out   = out_v[CH_FIQ];
  assign err_pulse = err_q;

  p_soft_set_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_wr && acc_word == OFS_SOFT && acc_wdata[0]) |=> soft_q);
  p_soft_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_wr && acc_word == OFS_SOFT_CLR && acc_wdata[0]) |=> !soft_q);
  p_line0_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_lines[0] && mask_v[CH_IRQ][0]) |=> irq_out);
  p_bad_write_inert_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_wr && (acc_word == OFS_IRQ_MSTAT || acc_word == OFS_IRQ_RAW ||
     acc_word == OFS_FIQ_MSTAT || acc_word == OFS_FIQ_RAW))
    |=> ($stable(mask_v) && $stable(soft_q) && err_pulse));
  p_bad_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_wr && (acc_word == OFS_IRQ_EN_CLR || acc_word == OFS_SOFT_CLR ||
     acc_word == OFS_FIQ_EN_CLR)) |=> (err_pulse && rd_data == '0));
  p_read_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(acc_en && !acc_wr) |=> $stable(rd_data));
endmodule

// File: tb/dualmask_intc_tb_top.sv
module dualmask_intc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] lines = '0;
  logic         acc_en = 1'b0;
  logic         acc_wr = 1'b0;
  logic [3:0]   acc_word = '0;
  logic [N-1:0] acc_wdata = '0;
  logic [N-1:0] rd_data;
  logic         irq_out, fiq_out, err_pulse;

  dualmask_intc #(.N_LINES(N)) dut_i (
    .clk(clk), .rst(rst), .irq_lines(lines),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_word(acc_word), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .irq_out(irq_out), .fiq_out(fiq_out), .err_pulse(err_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    int           at;
    int           sig;
    logic [N-1:0] val;
    string        req;
  } exp_t;
  exp_t q[$];

  logic [N-1:0] m_irq = '0;
  logic [N-1:0] m_fiq = '0;
  logic         m_soft = 1'b0;

  function automatic logic [N-1:0] m_raw();
    return lines | {{(N-1){1'b0}}, m_soft};
  endfunction

  function automatic bit legal_rd(int w);
    return (w == 0 || w == 1 || w == 2 || w == 4 || w == 8 || w == 9 || w == 10);
  endfunction

  function automatic bit legal_wr(int w);
    return (w == 2 || w == 3 || w == 4 || w == 5 || w == 10 || w == 11);
  endfunction

  function automatic logic [N-1:0] exp_rd(int w);
    logic [N-1:0] r;
    r = m_raw();
    case (w)
      0:       return r & m_irq;
      1, 9:    return r;
      2:       return m_irq;
      4:       return {{(N-1){1'b0}}, r[0]};
      8:       return r & m_fiq;
      10:      return m_fiq;
      default: return '0;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic push(int at, int sig, logic [N-1:0] v, string req);
    exp_t e;
    e.at = at; e.sig = sig; e.val = v; e.req = req;
    q.push_back(e);
  endtask

  function automatic logic [N-1:0] bit_of(logic b);
    return {{(N-1){1'b0}}, b};
  endfunction

  // monitor: compares every item due in the current cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at == cyc) begin
        case (q[i].sig)
          0: chk(q[i].req, "rd_data",   rd_data,            q[i].val);
          1: chk(q[i].req, "irq_out",   bit_of(irq_out),    q[i].val);
          2: chk(q[i].req, "fiq_out",   bit_of(fiq_out),    q[i].val);
          default: chk(q[i].req, "err_pulse", bit_of(err_pulse), q[i].val);
        endcase
        q.delete(i);
      end
    end
  end

  task automatic wr(int w, logic [N-1:0] d, string req);
    bit ok;
    ok = legal_wr(w);
    acc_en = 1'b1; acc_wr = 1'b1; acc_word = w[3:0]; acc_wdata = d;
    push(cyc + 1, 3, bit_of(!ok), req);
    if (ok) begin
      case (w)
        2:  m_irq = m_irq | d;
        3:  m_irq = m_irq & ~d;
        4:  if (d[0]) m_soft = 1'b1;
        5:  if (d[0]) m_soft = 1'b0;
        10: m_fiq = m_fiq | d;
        11: m_fiq = m_fiq & ~d;
        default: ;
      endcase
    end
    push(cyc + 2, 1, bit_of(|(m_raw() & m_irq)), req);
    push(cyc + 2, 2, bit_of(|(m_raw() & m_fiq)), req);
    push(cyc + 2, 3, '0, req);
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; acc_wdata = '0;
    @(negedge clk);
  endtask

  task automatic rd(int w, string req);
    acc_en = 1'b1; acc_wr = 1'b0; acc_word = w[3:0];
    push(cyc + 1, 0, exp_rd(w), req);
    push(cyc + 1, 3, bit_of(!legal_rd(w)), req);
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic set_lines(logic [N-1:0] v, string req);
    lines = v;
    push(cyc + 1, 1, bit_of(|(m_raw() & m_irq)), req);
    push(cyc + 1, 2, bit_of(|(m_raw() & m_fiq)), req);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset values at the ports
    chk("R1", "irq_out",   bit_of(irq_out),   '0);
    chk("R1", "fiq_out",   bit_of(fiq_out),   '0);
    chk("R1", "err_pulse", bit_of(err_pulse), '0);
    chk("R1", "rd_data",   rd_data,           '0);
    rd(2, "R1");
    rd(10, "R1");
    rd(4, "R1");

    // R2: raw and masked status
    set_lines(32'h0000_00F0, "R7");
    rd(1, "R2");
    rd(0, "R2");
    wr(2, 32'h0000_0030, "R3");
    rd(2, "R3");
    rd(0, "R2");
    repeat (3) @(negedge clk);
    chk("R2", "rd_data held", rd_data, 32'h0000_0030);
    wr(2, 32'h0000_0100, "R3");
    rd(2, "R3");
    wr(3, 32'h0000_0010, "R3");
    rd(2, "R3");
    rd(0, "R2");

    // R4: fast channel
    wr(10, 32'h0000_00C0, "R4");
    rd(10, "R4");
    rd(8, "R4");
    rd(9, "R4");
    wr(11, 32'hFFFF_FFFF, "R4");
    rd(10, "R4");
    rd(8, "R4");

    // R8: illegal accesses
    wr(0, 32'hFFFF_FFFF, "R8");
    wr(1, 32'hFFFF_FFFF, "R8");
    wr(9, 32'hFFFF_FFFF, "R8");
    wr(13, 32'hFFFF_FFFF, "R8");
    rd(2, "R8");
    rd(10, "R8");
    rd(3, "R8");
    rd(5, "R8");
    rd(11, "R8");
    rd(14, "R8");
    rd(1, "R8");

    // R5: soft bit on line 0
    set_lines('0, "R7");
    wr(4, 32'hFFFF_FFFE, "R5");
    rd(4, "R5");
    wr(2, 32'h0000_0001, "R5");
    wr(4, 32'h0000_0003, "R5");
    rd(4, "R5");
    rd(1, "R5");
    wr(5, 32'h0000_0000, "R5");
    rd(4, "R5");
    wr(5, 32'h0000_0001, "R5");
    rd(4, "R5");
    wr(4, 32'h0000_0001, "R5");

    // R6: soft clear in the same cycle input 0 rises
    lines = 32'h0000_0001;
    push(cyc + 1, 1, bit_of(1'b1), "R6");
    wr(5, 32'h0000_0001, "R6");
    rd(1, "R6");
    rd(4, "R6");
    set_lines('0, "R6");
    rd(4, "R6");

    // R7: level following on the top line, both channels
    wr(2, 32'h8000_0000, "R7");
    set_lines(32'h8000_0000, "R7");
    set_lines('0, "R7");
    wr(10, 32'h8000_0000, "R7");
    set_lines(32'h8000_0000, "R7");
    rd(8, "R7");
    set_lines('0, "R7");

    repeat (4) @(negedge clk);
    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R7 pending expectations actual=%0d expected=0", q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule